// File: doc/BRIEF.md
# Four-Lane Banked Byte/Word FIFO

This block is a data buffer for a serial-flash style controller. Its storage is four parallel byte lanes. Each lane holds `LANE_DEPTH` bytes. The host side has a 32-bit word port and an 8-bit byte port. A word access moves one byte in every lane at once, so the word view holds `LANES*LANE_DEPTH` bytes (64 by default). A byte access reaches lane 0 only, so the byte view holds `LANE_DEPTH` bytes (16 by default). The serial side moves one byte per accepted request to or from the shift engine. In word mode it steps through the lanes in rotating order. In byte mode it stays on lane 0.

The parameter `TX_SIDE` selects one of two builds. With `TX_SIDE=1` (transmit) the host pushes and the serial side pops. With `TX_SIDE=0` (receive) the serial side pushes and the host pops. Reads are first-word-fall-through: the read data shows the head entries before the pop request is made.

Seven status flags are latched, so each one stays set after its condition ends until software clears it. A flag that is cleared sets again at once if its condition still holds. An access that cannot complete does not change the stored data. Instead it sets a sticky illegal-access flag, and that flag drives an interrupt output. `byte_mode` may only change while the FIFO is empty.

Top module: `quad_lane_fifo`

## Requirements
- R1: A word push writes bits 8k+7:8k into lane k, and a word pop returns the head of lane k on bits 8k+7:8k. The word view holds 64 bytes, which is 16 words.
- R2: A push is refused and flagged as illegal, leaving the stored data unchanged, in each of these cases: a word push while any lane holds 16 bytes, a byte push while lane 0 holds 16 bytes, or a serial push into a selected lane that is full.
- R3: A pop is refused and flagged as illegal, leaving the stored data unchanged, in each of these cases: a word pop while any lane is empty, a byte pop while lane 0 is empty, or a serial pop from a selected lane that is empty.
- R4: In word mode the serial side visits lanes 0,1,2,3,0,… and advances only on an accepted transfer. As a result, transmitted serial bytes leave in little-endian order of the pushed words, and received serial bytes pack into words in that same order.
- R5: While `byte_mode`=1, the host byte port and the serial side use lane 0 only, and bits 31:8 of `host_wdata` are ignored. The following requests are illegal and have no effect: a word request in byte mode, a byte request in word mode, and a word request and a byte request in the same cycle.
- R6: Flag bit positions, where occupancy is the sum of all lanes in word mode and the count of lane 0 in byte mode, and cap is 64 or 16:
  - bit 0: full (occupancy = cap)
  - bit 1: half (occupancy ≥ cap/2)
  - bit 2: empty
  - bit 3: trigger (transmit: occupancy ≤ cap/4; receive: occupancy ≥ 3·cap/4)
  - bit 4: word available (word mode and every lane non-empty)
  - bit 5: byte available (byte mode and lane 0 non-empty)
  - bit 6: illegal access
- R7: Flags are zero in reset. Each flag sets on the clock edge after its condition holds. A 1 in `flag_clr` clears the flag at the next edge unless the condition still holds, in which case the flag stays set.
- R8: `illegal_irq` follows the latched illegal-access flag.
- R9: `host_rdata` shows the lane heads in word mode, or {24'h0, lane 0 head} in byte mode. `ser_rdata` shows the head of the selected lane.
- R10: A host push and a serial pop in the same cycle both complete, with no illegal flag, when their lanes allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_mode | input | 1 | 1 selects the byte view (lane 0 only) |
| host_word_req | input | 1 | Host word push (transmit) or word pop (receive) |
| host_byte_req | input | 1 | Host byte push (transmit) or byte pop (receive) |
| host_wdata | input | 8·LANES (32) | Host push data |
| host_rdata | output | 8·LANES (32) | Host read data, first-word-fall-through |
| ser_req | input | 1 | Serial-side pop (transmit) or push (receive) |
| ser_wdata | input | 8 | Serial push data |
| ser_rdata | output | 8 | Serial read data, head of the selected lane |
| flag_clr | input | 7 | One bit per flag; 1 clears the flag |
| flags | output | 7 | Latched status flags |
| illegal_irq | output | 1 | Illegal-access interrupt |

## Verification
The assertions check four properties on every cycle:
- no lane ever receives a push while full;
- no lane ever receives a pop while empty;
- in byte mode, lanes 1 to 3 are never touched;
- a latched flag holds until it is cleared, and an illegal event always reaches the interrupt.

Only the bench scenarios can show the remaining behaviour: the byte order across the lanes for both directions, the flag values at every occupancy from empty to full in both views, the re-assertion of a flag cleared while its condition holds, and the rotation resuming from a part-filled lane.

// File: rtl/qlf_pkg.sv
// Package: shared constants for the four-lane FIFO.
// Assumes flag positions are fixed; software decodes them.
package qlf_pkg;
    localparam int unsigned FLAG_W = 7;

    typedef enum int unsigned {
        F_FULL    = 0,
        F_HALF    = 1,
        F_EMPTY   = 2,
        F_TRIG    = 3,
        F_WORD    = 4,
        F_BYTE    = 5,
        F_ILLEGAL = 6
    } flag_idx_e;
endpackage

// File: rtl/qlf_lane.sv
// Module: one byte lane, a circular buffer with simultaneous push and pop.
// Assumes DEPTH is a power of two and that the caller never pushes when
// full nor pops when empty (checked below).
module qlf_lane #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Storage write; data needs no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CW'(DEPTH)));
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/qlf_steer.sv
// Module: decides which lanes push and pop each cycle, refuses requests
// that cannot complete, and keeps the rotating serial lane pointer.
// Assumes LANES is a power of two; TX_SIDE picks the direction.
module qlf_steer #(
    parameter int LANES   = 4,
    parameter bit TX_SIDE = 1'b1,
    localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_mode,
    input  logic               host_word_req,
    input  logic               host_byte_req,
    input  logic [LANES*8-1:0] host_wdata,
    input  logic               ser_req,
    input  logic [7:0]         ser_wdata,
    input  logic [LANES-1:0]   lane_full,
    input  logic [LANES-1:0]   lane_empty,
    output logic [LANES-1:0]   lane_push,
    output logic [LANES-1:0]   lane_pop,
    output logic [LANES*8-1:0] lane_wdata,
    output logic [LW-1:0]      sel_lane,
    output logic               illegal
);
    logic [LW-1:0] ser_lane;
    logic          host_one;
    logic          hw_ok;
    logic          hb_ok;
    logic          ser_ok;

    assign host_one = host_word_req ^ host_byte_req;
    assign sel_lane = byte_mode ? '0 : ser_lane;

    if (TX_SIDE) begin : g_tx
        logic unused_ser_wdata;
        assign unused_ser_wdata = ^ser_wdata;
        assign hw_ok  = host_word_req & host_one & ~byte_mode & ~(|lane_full);
        assign hb_ok  = host_byte_req & host_one & byte_mode & ~lane_full[0];
        assign ser_ok = ser_req & ~lane_empty[sel_lane];

        // Host fills lanes; serial side drains the selected lane.
        always_comb begin
            for (int i = 0; i < LANES; i++) begin
                lane_push[i] = hw_ok | (hb_ok && i == 0);
                lane_pop[i]  = ser_ok && (sel_lane == LW'(i));
                lane_wdata[i*8 +: 8] = hw_ok ? host_wdata[i*8 +: 8] : host_wdata[7:0];
            end
        end
    end else begin : g_rx
        logic unused_host_wdata;
        assign unused_host_wdata = ^host_wdata;
        assign hw_ok  = host_word_req & host_one & ~byte_mode & ~(|lane_empty);
        assign hb_ok  = host_byte_req & host_one & byte_mode & ~lane_empty[0];
        assign ser_ok = ser_req & ~lane_full[sel_lane];

        // Serial side fills the selected lane; host drains.
        always_comb begin
            for (int i = 0; i < LANES; i++) begin
                lane_push[i] = ser_ok && (sel_lane == LW'(i));
                lane_pop[i]  = hw_ok | (hb_ok && i == 0);
                lane_wdata[i*8 +: 8] = ser_wdata;
            end
        end
    end

    assign illegal = ((host_word_req | host_byte_req) & ~(hw_ok | hb_ok))
                   | (ser_req & ~ser_ok);

    // Rotating serial lane, advanced only by accepted word-mode transfers.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ser_lane <= '0;
        else if (ser_ok && !byte_mode)  ser_lane <= ser_lane + 1'b1;
    end
endmodule

// File: rtl/qlf_status.sv
// Module: computes live occupancy conditions for the active view and
// latches them into sticky flags with clear-by-one.
// Assumes lane counts are packed CW bits per lane, lane 0 lowest.
module qlf_status
    import qlf_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int DEPTH   = 16,
    parameter bit TX_SIDE = 1'b1,
    localparam int CW     = $clog2(DEPTH) + 1,
    localparam int OW     = $clog2(LANES*DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_mode,
    input  logic [LANES*CW-1:0]  lane_count,
    input  logic                 illegal,
    input  logic [FLAG_W-1:0]    flag_clr,
    output logic [FLAG_W-1:0]    flags,
    output logic                 illegal_irq
);
    localparam int W_CAP = LANES * DEPTH;
    localparam int B_CAP = DEPTH;

    logic [OW-1:0]     occ;
    logic [OW-1:0]     cap;
    logic [OW-1:0]     tx_lvl;
    logic [OW-1:0]     rx_lvl;
    logic              all_ne;
    logic [FLAG_W-1:0] live;

    // Occupancy of the active view and whether every lane holds data.
    always_comb begin
        logic [OW-1:0] sum;
        sum    = '0;
        all_ne = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            sum = sum + OW'(lane_count[i*CW +: CW]);
            if (lane_count[i*CW +: CW] == '0) all_ne = 1'b0;
        end
        occ    = byte_mode ? OW'(lane_count[CW-1:0]) : sum;
        cap    = byte_mode ? OW'(B_CAP) : OW'(W_CAP);
        tx_lvl = byte_mode ? OW'(B_CAP / 4) : OW'(W_CAP / 4);
        rx_lvl = byte_mode ? OW'(B_CAP - B_CAP / 4) : OW'(W_CAP - W_CAP / 4);
    end

    // Live condition vector.
    always_comb begin
        live            = '0;
        live[F_FULL]    = (occ == cap);
        live[F_HALF]    = (occ >= (cap >> 1));
        live[F_EMPTY]   = (occ == '0);
        live[F_TRIG]    = TX_SIDE ? (occ <= tx_lvl) : (occ >= rx_lvl);
        live[F_WORD]    = ~byte_mode & all_ne;
        live[F_BYTE]    = byte_mode & (lane_count[CW-1:0] != '0);
        live[F_ILLEGAL] = illegal;
    end

    // Sticky flags: clear-by-one, live conditions re-set them.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | live;
    end

    assign illegal_irq = flags[F_ILLEGAL];

    for (genvar g = 0; g < FLAG_W; g++) begin : g_stick
        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !flag_clr[g]) |=> flags[g]);
    end

    a_r8_illegal_irq: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal_irq);
endmodule

// File: rtl/quad_lane_fifo.sv
// Module: four-lane banked FIFO top. Instantiates the lanes, the request
// steering and the status flags, and forms the read data views.
// Assumes byte_mode changes only while the FIFO is empty.
module quad_lane_fifo
    import qlf_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int LANE_DEPTH = 16,
    parameter bit TX_SIDE    = 1'b1,
    localparam int CW        = $clog2(LANE_DEPTH) + 1,
    localparam int LW        = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_mode,
    input  logic               host_word_req,
    input  logic               host_byte_req,
    input  logic [LANES*8-1:0] host_wdata,
    output logic [LANES*8-1:0] host_rdata,
    input  logic               ser_req,
    input  logic [7:0]         ser_wdata,
    output logic [7:0]         ser_rdata,
    input  logic [FLAG_W-1:0]  flag_clr,
    output logic [FLAG_W-1:0]  flags,
    output logic               illegal_irq
);
    logic [LANES-1:0]    lane_push;
    logic [LANES-1:0]    lane_pop;
    logic [LANES-1:0]    lane_full;
    logic [LANES-1:0]    lane_empty;
    logic [LANES*8-1:0]  lane_wdata;
    logic [LANES*8-1:0]  heads;
    logic [LANES*CW-1:0] counts;
    logic [LW-1:0]       sel_lane;
    logic                illegal;

    qlf_steer #(.LANES(LANES), .TX_SIDE(TX_SIDE)) u_steer (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_mode     (byte_mode),
        .host_word_req (host_word_req),
        .host_byte_req (host_byte_req),
        .host_wdata    (host_wdata),
        .ser_req       (ser_req),
        .ser_wdata     (ser_wdata),
        .lane_full     (lane_full),
        .lane_empty    (lane_empty),
        .lane_push     (lane_push),
        .lane_pop      (lane_pop),
        .lane_wdata    (lane_wdata),
        .sel_lane      (sel_lane),
        .illegal       (illegal)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        qlf_lane #(.DEPTH(LANE_DEPTH), .DW(8)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (lane_push[i]),
            .pop   (lane_pop[i]),
            .wdata (lane_wdata[i*8 +: 8]),
            .head  (heads[i*8 +: 8]),
            .count (counts[i*CW +: CW]),
            .full  (lane_full[i]),
            .empty (lane_empty[i])
        );
    end

    qlf_status #(.LANES(LANES), .DEPTH(LANE_DEPTH), .TX_SIDE(TX_SIDE)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_mode   (byte_mode),
        .lane_count  (counts),
        .illegal     (illegal),
        .flag_clr    (flag_clr),
        .flags       (flags),
        .illegal_irq (illegal_irq)
    );

    // Host read view: all lane heads, or lane 0 zero-extended in byte mode.
    always_comb begin
        host_rdata = heads;
        if (byte_mode) begin
            host_rdata      = '0;
            host_rdata[7:0] = heads[7:0];
        end
    end

    assign ser_rdata = heads[sel_lane*8 +: 8];

    a_r5_byte_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |-> ((lane_push[LANES-1:1] | lane_pop[LANES-1:1]) == '0));
endmodule

// File: tb/tb_quad_lane_fifo.sv
module tb_quad_lane_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Transmit-build signals
    logic        t_bm, t_hw, t_hb, t_sr;
    logic [31:0] t_wd, t_rd;
    logic [7:0]  t_swd, t_srd;
    logic [6:0]  t_clr, t_flags;
    logic        t_irq;
    // Receive-build signals
    logic        r_bm, r_hw, r_hb, r_sr;
    logic [31:0] r_wd, r_rd;
    logic [7:0]  r_swd, r_srd;
    logic [6:0]  r_clr, r_flags;
    logic        r_irq;

    quad_lane_fifo #(.TX_SIDE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .byte_mode(t_bm),
        .host_word_req(t_hw), .host_byte_req(t_hb), .host_wdata(t_wd),
        .host_rdata(t_rd), .ser_req(t_sr), .ser_wdata(t_swd),
        .ser_rdata(t_srd), .flag_clr(t_clr), .flags(t_flags),
        .illegal_irq(t_irq));

    quad_lane_fifo #(.TX_SIDE(1'b0)) dut_rx (
        .clk(clk), .rst_n(rst_n), .byte_mode(r_bm),
        .host_word_req(r_hw), .host_byte_req(r_hb), .host_wdata(r_wd),
        .host_rdata(r_rd), .ser_req(r_sr), .ser_wdata(r_swd),
        .ser_rdata(r_srd), .flag_clr(r_clr), .flags(r_flags),
        .illegal_irq(r_irq));

    logic [7:0] q[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] bx(input int k);
        return 8'((k * 29 + 3) & 255);
    endfunction

    function automatic logic [31:0] wordv(input int w);
        return {bx(4*w+3), bx(4*w+2), bx(4*w+1), bx(4*w)};
    endfunction

    function automatic logic [6:0] expf(input bit tx, input bit bm, input int n, input bit ill);
        int cap;
        logic [6:0] f;
        cap  = bm ? 16 : 64;
        f    = '0;
        f[0] = (n == cap);
        f[1] = (n >= cap / 2);
        f[2] = (n == 0);
        f[3] = tx ? (n <= cap / 4) : (n >= cap - cap / 4);
        f[4] = !bm && (n >= 4);
        f[5] = bm && (n > 0);
        f[6] = ill;
        return f;
    endfunction

    // Clear all flags in one edge, leaving only live conditions.
    task automatic t_clear();
        t_clr = 7'h7F; step(); t_clr = '0;
    endtask
    task automatic r_clear();
        r_clr = 7'h7F; step(); r_clr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        {t_bm, t_hw, t_hb, t_sr, t_wd, t_swd, t_clr} = '0;
        {r_bm, r_hw, r_hb, r_sr, r_wd, r_swd, r_clr} = '0;
        rst_n = 1'b0;
        repeat (3) step();
        chk("R7 reset tx flags", 32'(t_flags), 32'h0);
        chk("R8 reset tx irq", 32'(t_irq), 32'h0);
        chk("R7 reset rx flags", 32'(r_flags), 32'h0);
        rst_n = 1'b1;
        step();
        chk("R6 tx empty after reset", 32'(t_flags), 32'(expf(1, 0, 0, 0)));
        chk("R6 rx empty after reset", 32'(r_flags), 32'(expf(0, 0, 0, 0)));

        // ---------- Transmit build, word mode ----------
        for (int w = 0; w < 16; w++) begin
            t_hw = 1'b1; t_wd = wordv(w);
            for (int b = 0; b < 4; b++) q.push_back(bx(4*w + b));
            step(); t_hw = 1'b0;
            t_clear();
            chk("R6 tx word fill flags", 32'(t_flags), 32'(expf(1, 0, 4*(w+1), 0)));
        end
        t_hw = 1'b1; t_wd = 32'hDEADBEEF; step(); t_hw = 1'b0; step();
        chk("R2 tx word push into full", 32'(t_flags[6]), 32'h1);
        chk("R8 tx irq on overflow", 32'(t_irq), 32'h1);
        t_clear();
        chk("R8 tx irq cleared", 32'(t_irq), 32'h0);
        chk("R7 full re-asserts after clear", 32'(t_flags), 32'(expf(1, 0, 64, 0)));

        for (int j = 0; j < 64; j++) begin
            chk("R4 tx serial byte order R1", 32'(t_srd), 32'(q[0]));
            t_sr = 1'b1; step(); t_sr = 1'b0;
            void'(q.pop_front());
            t_clear();
            chk("R6 tx drain flags", 32'(t_flags), 32'(expf(1, 0, 63 - j, 0)));
        end
        t_sr = 1'b1; step(); t_sr = 1'b0; step();
        chk("R3 tx serial pop empty", 32'(t_irq), 32'h1);
        t_clear();
        chk("R7 illegal clears when gone", 32'(t_flags), 32'(expf(1, 0, 0, 0)));

        // Simultaneous word push and serial pop
        t_hw = 1'b1; t_wd = wordv(20);
        for (int b = 0; b < 4; b++) q.push_back(bx(80 + b));
        step();
        for (int c = 0; c < 6; c++) begin
            t_hw = 1'b1; t_wd = wordv(21 + c); t_sr = 1'b1;
            chk("R10 tx concurrent serial byte", 32'(t_srd), 32'(q[0]));
            step();
            void'(q.pop_front());
            for (int b = 0; b < 4; b++) q.push_back(bx(4*(21 + c) + b));
        end
        t_hw = 1'b0; t_sr = 1'b0;
        step();
        chk("R10 no illegal on concurrent ops", 32'(t_irq), 32'h0);
        while (q.size() > 0) begin
            chk("R4 tx order after concurrency", 32'(t_srd), 32'(q[0]));
            t_sr = 1'b1; step(); t_sr = 1'b0;
            void'(q.pop_front());
        end
        t_clear();
        chk("R6 tx empty after concurrency", 32'(t_flags), 32'(expf(1, 0, 0, 0)));

        // Byte request in word mode is illegal and stores nothing
        t_hb = 1'b1; t_wd = 32'h55; step(); t_hb = 1'b0; step();
        chk("R5 byte push in word mode flagged", 32'(t_irq), 32'h1);
        t_clear();
        chk("R5 byte push in word mode stored nothing", 32'(t_flags), 32'(expf(1, 0, 0, 0)));

        // ---------- Transmit build, byte mode ----------
        t_bm = 1'b1;
        t_clear();
        chk("R6 tx byte view empty", 32'(t_flags), 32'(expf(1, 1, 0, 0)));
        for (int n = 1; n <= 16; n++) begin
            t_hb = 1'b1; t_wd = {24'hFFFFFF, bx(200 + n)};
            q.push_back(bx(200 + n));
            step(); t_hb = 1'b0;
            t_clear();
            chk("R6 tx byte view fill flags", 32'(t_flags), 32'(expf(1, 1, n, 0)));
        end
        t_hb = 1'b1; t_wd = 32'h11; step(); t_hb = 1'b0; step();
        chk("R2 tx byte push into full lane", 32'(t_irq), 32'h1);
        t_clear();
        t_hw = 1'b1; t_wd = 32'h22334455; step(); t_hw = 1'b0; step();
        chk("R5 word push in byte mode flagged", 32'(t_irq), 32'h1);
        t_clear();
        chk("R5 byte view unchanged", 32'(t_flags), 32'(expf(1, 1, 16, 0)));
        for (int j = 0; j < 16; j++) begin
            chk("R5 tx lane0 byte order R9", 32'(t_srd), 32'(q[0]));
            t_sr = 1'b1; step(); t_sr = 1'b0;
            void'(q.pop_front());
        end
        t_sr = 1'b1; step(); t_sr = 1'b0; step();
        chk("R3 tx byte-view serial pop empty", 32'(t_irq), 32'h1);
        t_clear();
        t_hw = 1'b1; t_hb = 1'b1; t_wd = 32'h77; step();
        t_hw = 1'b0; t_hb = 1'b0; step();
        chk("R5 both host requests flagged", 32'(t_irq), 32'h1);
        t_clear();
        chk("R5 both host requests stored nothing", 32'(t_flags), 32'(expf(1, 1, 0, 0)));

        // ---------- Receive build, word mode ----------
        for (int n = 1; n <= 64; n++) begin
            r_sr = 1'b1; r_swd = bx(n - 1); step(); r_sr = 1'b0;
            r_clear();
            chk("R6 rx serial fill flags", 32'(r_flags), 32'(expf(0, 0, n, 0)));
        end
        r_sr = 1'b1; r_swd = 8'hEE; step(); r_sr = 1'b0; step();
        chk("R2 rx serial push into full", 32'(r_irq), 32'h1);
        r_clear();
        for (int w = 0; w < 16; w++) begin
            chk("R1 rx word pack R4", r_rd, wordv(w));
            r_hw = 1'b1; step(); r_hw = 1'b0;
        end
        r_clear();
        chk("R6 rx empty after word pops", 32'(r_flags), 32'(expf(0, 0, 0, 0)));
        r_hw = 1'b1; step(); r_hw = 1'b0; step();
        chk("R3 rx word pop empty", 32'(r_irq), 32'h1);
        r_clear();
        for (int n = 0; n < 3; n++) begin
            r_sr = 1'b1; r_swd = bx(100 + n); step(); r_sr = 1'b0;
        end
        r_hw = 1'b1; step(); r_hw = 1'b0; step();
        chk("R3 rx word pop with one lane empty", 32'(r_irq), 32'h1);
        r_clear();
        for (int n = 3; n < 8; n++) begin
            r_sr = 1'b1; r_swd = bx(100 + n); step(); r_sr = 1'b0;
        end
        chk("R4 rx rotation resumes first word", r_rd, wordv(25));
        r_hw = 1'b1; step(); r_hw = 1'b0;
        chk("R4 rx rotation resumes second word", r_rd, wordv(26));
        r_hw = 1'b1; step(); r_hw = 1'b0;
        r_clear();
        chk("R6 rx empty after partial", 32'(r_flags), 32'(expf(0, 0, 0, 0)));

        // ---------- Receive build, byte mode ----------
        r_bm = 1'b1;
        for (int n = 1; n <= 16; n++) begin
            r_sr = 1'b1; r_swd = bx(300 + n); step(); r_sr = 1'b0;
            r_clear();
            chk("R6 rx byte view fill flags", 32'(r_flags), 32'(expf(0, 1, n, 0)));
        end
        r_sr = 1'b1; r_swd = 8'h99; step(); r_sr = 1'b0; step();
        chk("R2 rx serial push into full lane0", 32'(r_irq), 32'h1);
        r_clear();
        for (int n = 1; n <= 16; n++) begin
            chk("R9 rx byte pop zero-extended R5", r_rd, {24'h0, bx(300 + n)});
            r_hb = 1'b1; step(); r_hb = 1'b0;
        end
        r_hb = 1'b1; step(); r_hb = 1'b0; step();
        chk("R3 rx byte pop empty", 32'(r_irq), 32'h1);
        r_clear();
        chk("R7 rx flags after clear", 32'(r_flags), 32'(expf(0, 1, 0, 0)));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule